// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block holds a set of 32-bit mailbox words that processor cores use to signal one another. By default there are four cores with four mailboxes each, sixteen words in all. A sender sets bits in a word through a set alias. The receiver reads the word and clears the bits it has handled through a clear alias at another address. While a word is nonzero it raises a pending flag for its owning core. That flag goes out on either an IRQ-pending or a FIQ-pending vector, and a control byte per core selects which one. A downstream interrupt router consumes the two vectors.

The register interface takes one access per cycle: a write strobe or a read strobe, with a byte address and 32-bit write data.

- Byte addresses 0x50 + 4*c hold the control byte of core c.
- Byte addresses 0x80 + 4*i are the set aliases.
- Byte addresses 0xC0 + 4*i are the clear aliases, where i = c*4 + k names mailbox k of core c.
- Address bits [1:0] are ignored.
- Read data is registered: it appears in the cycle after the read strobe. It is zero in any cycle that does not follow a read.

Top module: `mbox_bank`

## Requirements
- R1: A write to the set alias of mailbox i (byte address 0x80 + 4*i) ORs the write data into that mailbox. Bits already set stay set.
- R2: A write to the clear alias of mailbox i (byte address 0xC0 + 4*i) clears every mailbox bit that is 1 in the write data. All other bits keep their value.
- R3: A read of the clear alias of mailbox i returns the current 32-bit mailbox contents on the read-data output one cycle after the read strobe. In any cycle that does not follow a read, the read-data output is zero.
- R4: A read of a set alias or of an unmapped address returns zero. A write to an unmapped address changes no mailbox and no control byte.
- R5: Mailbox index i = c*4 + k belongs to core c, slot k. A write to one index leaves every other mailbox unchanged.
- R6: The control byte of core c sits at byte address 0x50 + 4*c. A write keeps only write-data bits [7:0], and a read returns that byte zero-extended.
- R7: Pending bit c*4 + k of the IRQ vector is 1 when mailbox c*4 + k is nonzero, control bit k of core c is 1, and control bit k+4 is 0.
- R8: When mailbox c*4 + k is nonzero and control bit k+4 of core c is 1, FIQ pending bit c*4 + k is 1 and IRQ pending bit c*4 + k is 0. This holds whatever the value of control bit k.
- R9: A nonzero mailbox whose two enable bits are both 0 raises neither pending bit.
- R10: Reset, active low, clears all mailboxes and all control bytes, so both pending vectors read zero.
- R11: The pending vectors reflect a write in the cycle right after the clock edge that takes the write. They do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pend | output | 16 | IRQ-pending flag per mailbox, bit c*4+k |
| fiq_pend | output | 16 | FIQ-pending flag per mailbox, bit c*4+k |

## Verification
The set and clear aliases are tried with values that overlap and values that are disjoint. This shows whether the OR and AND-NOT really merge into the stored word rather than overwrite it. Control bytes are tried in four forms, one for each enable combination: IRQ only, FIQ only, both, and neither. This separates the FIQ-wins rule from plain masking. A sweep writes a distinct value to every mailbox and then reads all of them back, which exposes any index or address mix-up. Writes to unmapped space, reads of the set aliases and a reset in mid-run confirm that nothing outside the mapped accesses disturbs stored state.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   typedef enum logic [1:0] {
      RG_NONE = 2'd0,
      RG_CTRL = 2'd1,
      RG_SET  = 2'd2,
      RG_CLR  = 2'd3
   } region_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
   import mbox_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_CORES = 4,
   parameter int NUM_BOXES = 16,
   parameter int CTRL_BASE = 'h50,
   parameter int SET_BASE  = 'h80,
   parameter int CLR_BASE  = 'hC0,
   parameter int IDX_W     = $clog2(NUM_BOXES),
   parameter int CORE_W    = $clog2(NUM_CORES)
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [IDX_W-1:0]  box_idx,
   output logic [CORE_W-1:0] core_idx
);
   localparam int EW = ADDR_W + 1;
   localparam logic [ADDR_W:0] CTRL_LO = EW'(CTRL_BASE);
   localparam logic [ADDR_W:0] CTRL_HI = EW'(CTRL_BASE + 4 * NUM_CORES);
   localparam logic [ADDR_W:0] SET_LO  = EW'(SET_BASE);
   localparam logic [ADDR_W:0] SET_HI  = EW'(SET_BASE + 4 * NUM_BOXES);
   localparam logic [ADDR_W:0] CLR_LO  = EW'(CLR_BASE);
   localparam logic [ADDR_W:0] CLR_HI  = EW'(CLR_BASE + 4 * NUM_BOXES);

   logic [ADDR_W:0] a_ext, off_ctrl, off_set, off_clr;

   always_comb begin
      a_ext    = {1'b0, addr};
      off_ctrl = a_ext - CTRL_LO;
      off_set  = a_ext - SET_LO;
      off_clr  = a_ext - CLR_LO;
      region   = RG_NONE;
      box_idx  = '0;
      core_idx = '0;
      if (a_ext >= CTRL_LO && a_ext < CTRL_HI) begin
         region   = RG_CTRL;
         core_idx = CORE_W'(off_ctrl >> 2);
      end else if (a_ext >= SET_LO && a_ext < SET_HI) begin
         region  = RG_SET;
         box_idx = IDX_W'(off_set >> 2);
      end else if (a_ext >= CLR_LO && a_ext < CLR_HI) begin
         region  = RG_CLR;
         box_idx = IDX_W'(off_clr >> 2);
      end
   end
endmodule

// File: rtl/mbox_word.sv
module mbox_word #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] after_set, nxt;

   always_comb begin
      after_set = set_en ? (q | wdata) : q;
      nxt       = clr_en ? (after_set & ~wdata) : after_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R1: a set merges the data in without dropping earlier bits
   assert_set_merges_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_en && !clr_en) |->
         (((q & $past(wdata)) == $past(wdata)) && ((q & $past(q)) == $past(q))));

   // R2: after a clear, none of the written ones remain
   assert_clear_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_en) |-> ((q & $past(wdata)) == '0));

   // R5: an access aimed elsewhere leaves this word alone
   assert_untouched_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!set_en && !clr_en) |-> (q == $past(q)));
endmodule

// File: rtl/mbox_steer.sv
module mbox_steer #(
   parameter int SLOTS  = 4,
   parameter int CTRL_W = 2 * SLOTS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   input  logic [SLOTS-1:0]  nonzero,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [SLOTS-1:0]  irq,
   output logic [SLOTS-1:0]  fiq
);
   if (CTRL_W != 2 * SLOTS) begin : g_bad_ctrl_w
      $error("mbox_steer: CTRL_W must equal 2*SLOTS");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wdata;
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign fiq[k] = nonzero[k] & ctrl_q[k + SLOTS];
      assign irq[k] = nonzero[k] & ctrl_q[k] & ~ctrl_q[k + SLOTS];
   end

   // R6: a control write lands exactly the low byte it was given
   assert_ctrl_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> (ctrl_q == $past(wdata)));

   // R6: without a write the control byte keeps its value
   assert_ctrl_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_en) |-> $stable(ctrl_q));
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
   import mbox_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int NUM_CORES = 4,
   parameter int SLOTS     = 4,
   parameter int CTRL_BASE = 'h50,
   parameter int SET_BASE  = 'h80,
   parameter int CLR_BASE  = 'hC0,
   parameter bit READ_REG  = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic [NUM_CORES*SLOTS-1:0]  irq_pend,
   output logic [NUM_CORES*SLOTS-1:0]  fiq_pend
);
   localparam int NUM_BOXES = NUM_CORES * SLOTS;
   localparam int IDX_W     = $clog2(NUM_BOXES);
   localparam int CORE_W    = $clog2(NUM_CORES);
   localparam int CTRL_W    = 2 * SLOTS;

   // elaboration-time parameter checks
   if (NUM_CORES < 2 || SLOTS < 1) begin : g_bad_count
      $error("mbox_bank: need at least two cores and one slot");
   end
   if (CTRL_W > DATA_W) begin : g_bad_width
      $error("mbox_bank: control byte wider than data bus");
   end
   if (CTRL_BASE + 4 * NUM_CORES > SET_BASE ||
       SET_BASE + 4 * NUM_BOXES > CLR_BASE ||
       CLR_BASE + 4 * NUM_BOXES > (1 << ADDR_W)) begin : g_bad_map
      $error("mbox_bank: address ranges overlap or overflow");
   end

   region_e           region;
   logic [IDX_W-1:0]  box_idx;
   logic [CORE_W-1:0] core_idx;

   mbox_decode #(
      .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .NUM_BOXES(NUM_BOXES),
      .CTRL_BASE(CTRL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
      .IDX_W(IDX_W), .CORE_W(CORE_W)
   ) u_decode (
      .addr(bus_addr), .region(region), .box_idx(box_idx), .core_idx(core_idx)
   );

   logic [DATA_W-1:0] box_q  [NUM_BOXES];
   logic [CTRL_W-1:0] ctrl_q [NUM_CORES];

   for (genvar i = 0; i < NUM_BOXES; i++) begin : g_box
      logic hit;
      assign hit = bus_wr && (box_idx == IDX_W'(i));
      mbox_word #(.DATA_W(DATA_W)) u_word (
         .clk(clk), .rst_n(rst_n),
         .set_en(hit && region == RG_SET),
         .clr_en(hit && region == RG_CLR),
         .wdata(bus_wdata), .q(box_q[i])
      );
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [SLOTS-1:0] nz;
      for (genvar k = 0; k < SLOTS; k++) begin : g_nz
         assign nz[k] = |box_q[c * SLOTS + k];
      end
      mbox_steer #(.SLOTS(SLOTS), .CTRL_W(CTRL_W)) u_steer (
         .clk(clk), .rst_n(rst_n),
         .wr_en(bus_wr && region == RG_CTRL && core_idx == CORE_W'(c)),
         .wdata(bus_wdata[CTRL_W-1:0]), .nonzero(nz),
         .ctrl_q(ctrl_q[c]),
         .irq(irq_pend[c * SLOTS +: SLOTS]),
         .fiq(fiq_pend[c * SLOTS +: SLOTS])
      );
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      case (region)
         RG_CTRL: rd_mux = DATA_W'(ctrl_q[core_idx]);
         RG_CLR:  rd_mux = box_q[box_idx];
         default: rd_mux = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= bus_rd ? rd_mux : '0;
      end
      assign bus_rdata = rdata_q;

      // R4: reads outside the readable ranges come back as zero
      assert_blank_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(bus_rd) && $past(region) != RG_CTRL && $past(region) != RG_CLR)
            |-> (bus_rdata == '0));
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end
endmodule

// File: tb/mbox_bank_bench.sv
module mbox_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_pend, fiq_pend;

   always #5 clk = ~clk;

   mbox_bank u_mbox_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pend(irq_pend), .fiq_pend(fiq_pend)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] mb [16];
   logic [7:0]  cr [4];
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_seen = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] model_rd(input logic [7:0] a);
      if (a >= 8'h50 && a < 8'h60) return {24'd0, cr[(a - 8'h50) >> 2]};
      if (a >= 8'hC0)              return mb[(a - 8'hC0) >> 2];
      return 32'd0;
   endfunction

   task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
      if (a >= 8'h50 && a < 8'h60)      cr[(a - 8'h50) >> 2] = d[7:0];
      else if (a >= 8'h80 && a < 8'hC0) mb[(a - 8'h80) >> 2] |= d;
      else if (a >= 8'hC0)              mb[(a - 8'hC0) >> 2] &= ~d;
   endtask

   task automatic model_clear();
      for (int i = 0; i < 16; i++) mb[i] = '0;
      for (int c = 0; c < 4; c++)  cr[c] = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_wr(a, d);
   endtask

   // driver: push expected read data; the monitor compares it later
   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(model_rd(a));
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic check_pend(input string tag);
      logic [15:0] ei, ef;
      for (int c = 0; c < 4; c++)
         for (int k = 0; k < 4; k++) begin
            ef[c*4+k] = (mb[c*4+k] != 0) && cr[c][k+4];
            ei[c*4+k] = (mb[c*4+k] != 0) && cr[c][k] && !cr[c][k+4];
         end
      chk({tag, " irq"}, {16'd0, irq_pend}, {16'd0, ei});
      chk({tag, " fiq"}, {16'd0, fiq_pend}, {16'd0, ef});
   endtask

   // monitor: compare registered read data one cycle after each read
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R3 unexpected read actual=%h expected=none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, bus_rdata, e);
         end
      end else if (rst_n) begin
         chk("R3 idle rdata", bus_rdata, 32'd0);
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_pend("R10 reset pending");
      rd(8'hC0, "R10 reset box0");
      rd(8'h5C, "R10 reset ctrl3");

      // IRQ-only steering on core 0 slot 0
      wr(8'h50, 32'h0000_0001);
      // R11: before the write edge the pending flag stays low
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h80; bus_wdata = 32'h0000_00F0;
      #1 chk("R11 before edge", {16'd0, irq_pend}, 32'd0);
      @(negedge clk);
      bus_wr = 1'b0;
      model_wr(8'h80, 32'h0000_00F0);
      check_pend("R11 R7 after edge");
      wr(8'h80, 32'h0000_000F);
      rd(8'hC0, "R1 R3 set merge");
      wr(8'hC0, 32'h0000_000F);
      rd(8'hC0, "R2 partial clear");
      check_pend("R7 still pending");
      wr(8'hC0, 32'hFFFF_FFFF);
      check_pend("R2 R7 cleared");

      // both enables: FIQ wins, core 2 slot 1 = index 9
      wr(8'h58, 32'h0000_0022);
      wr(8'hA4, 32'h8000_0000);
      check_pend("R8 fiq only");
      rd(8'hE4, "R3 box9");

      // no enables on core 3, then FIQ only for slot 3
      wr(8'hBC, 32'h0000_1000);
      check_pend("R9 masked");
      wr(8'h5C, 32'h0000_0080);
      check_pend("R11 R8 fiq enable");

      // control keeps only the low byte
      wr(8'h54, 32'hABCD_1234);
      rd(8'h54, "R6 low byte only");

      // set alias and unmapped reads, unmapped write
      rd(8'hA4, "R4 set alias read");
      rd(8'h00, "R4 unmapped read");
      rd(8'h60, "R4 unmapped gap read");
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h7C, 32'hFFFF_FFFF);
      rd(8'hE4, "R4 box9 after unmapped write");
      rd(8'h58, "R4 ctrl2 after unmapped write");
      check_pend("R4 pending after unmapped write");

      // index sweep
      for (int i = 0; i < 16; i++) wr(8'(8'h80 + 4*i), (32'h1 << i) | (32'(i) << 20));
      for (int i = 0; i < 16; i++) rd(8'(8'hC0 + 4*i), $sformatf("R5 box%0d", i));
      wr(8'h50, 32'h0000_000F);
      wr(8'h54, 32'h0000_00F0);
      wr(8'h58, 32'h0000_00A5);
      wr(8'h5C, 32'h0000_0000);
      check_pend("R7 R8 R9 sweep");
      wr(8'hC8, 32'hFFFF_FFFF);
      rd(8'hC4, "R5 neighbour box1");
      rd(8'hCC, "R5 neighbour box3");
      check_pend("R2 R5 box2 cleared");

      // reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      model_clear();
      check_pend("R10 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      rd(8'hC4, "R10 box1 after reset");
      rd(8'h54, "R10 ctrl1 after reset");
      check_pend("R10 after reset");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule